// File: doc/BRIEF.md
# Split-Kind Direct-Mapped Address Translation Cache

This block maps a virtual address to a physical address for three kinds of access: instruction fetch, data load and data store. It is a direct-mapped cache of page translations. Each set holds one physical page base, shared by all kinds. Each set also keeps a separate page tag and valid bit for every kind. A translation installed for one kind hits only for requests of that kind.

The lookup is combinational. A request carries a virtual address and two flags, one for fetch and one for store. In the same cycle the block answers with either a hit and the translated physical address, or a miss. Page-table walking, permission checks and fault handling sit outside the block. On a miss, an outside agent walks the tables and writes the result back through the refill port. A flush input discards every translation in one cycle, for example when the address space changes.

Top module: `xlt_cache`

## Requirements
- R1: The set index is the virtual page number modulo SETS, that is `req_vaddr[PG_SHIFT +: log2(SETS)]` (bits 19:12 with the defaults); a page whose number differs by a multiple of SETS maps to the same set and misses there unless its own tag is installed.
- R2: The access kind of a request is fetch when `req_fetch` is 1, whatever `req_store` is; otherwise store when `req_store` is 1; otherwise load.
- R3: `hit` is 1 only when `req_valid` is 1, the selected kind's valid bit in the indexed set is 1, and that kind's stored tag equals `req_vaddr[VA_W-1:PG_SHIFT]`.
- R4: On a hit, `paddr` equals the set's stored base plus the zero-extended page offset `req_vaddr[PG_SHIFT-1:0]`, modulo 2^PA_W; when `hit` is 0, `paddr` is 0.
- R5: `miss` equals `req_valid` and not `hit`; with `req_valid` at 0 both `hit` and `miss` are 0.
- R6: A refill accepted at a clock edge writes `fill_pbase` as the set's base, stores the page number of `fill_vaddr` as the tag of kind `fill_kind`, and sets that kind's valid bit. It clears the valid bits of the other two kinds in that set. The result is visible from the next cycle.
- R7: `fill_kind` encodes 0 = load, 1 = store, 2 = fetch; the value 3 is reserved, and a refill carrying it changes nothing.
- R8: `flush` high at a clock edge clears every valid bit of every kind. A refill presented in the same cycle is dropped.
- R9: When a lookup and a refill address the same set in one cycle, the lookup answers from the contents held before that refill.
- R10: A synchronous active-high `rst` clears every valid bit, so every request misses after reset. A refill presented during reset is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_store | input | 1 | Request is a store (when not a fetch) |
| fill_valid | input | 1 | Refill write present |
| fill_vaddr | input | VA_W | Virtual address of the page being installed |
| fill_kind | input | 2 | Access kind of the refill (0 load, 1 store, 2 fetch, 3 reserved) |
| fill_pbase | input | PA_W | Physical base word for the set |
| flush | input | 1 | Invalidate all translations |
| hit | output | 1 | Translation found for the request's kind |
| paddr | output | PA_W | Translated physical address, 0 when no hit |
| miss | output | 1 | Request present and not found |

## Verification
The assertions assume that `rst` is held high from time zero through the first clock edge. No property then looks at a cycle from before reset. The properties that predict a hit or a miss after a refill look only one cycle ahead. They assume the request in that cycle names the same page as the refill. The bench holds reset from time zero and only ever drives inputs on the falling edge. Its random stimulus draws addresses from a small pool of pages that collide on a few sets. This makes refill-then-lookup, kind eviction and aliasing pairs frequent. It also sends reserved kind codes and flushes at random, so these cases fall inside what the properties cover.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  localparam int unsigned NUM_KINDS = 3;

  // fetch flag dominates, then store, else load
  function automatic acc_kind_e req_kind(input logic is_fetch, input logic is_store);
    if (is_fetch) return KIND_FETCH;
    if (is_store) return KIND_STORE;
    return KIND_LOAD;
  endfunction

endpackage

// File: rtl/xlt_ram.sv
module xlt_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 20
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/xlt_valid.sv
module xlt_valid #(
  parameter int unsigned SETS  = 256,
  parameter int unsigned KINDS = 3
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic [1:0]              wr_kind,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  output logic [KINDS-1:0]        rd_bits
);

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    logic [SETS-1:0] bits_q;

    always_ff @(posedge clk) begin
      if (clr) begin
        bits_q <= '0;
      end else if (wr_en) begin
        // set own kind, drop the others in this set
        bits_q[wr_idx] <= (wr_kind == 2'(k));
      end
    end

    assign rd_bits[k] = bits_q[rd_idx];
  end

endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
  import xlt_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 12,
  parameter int unsigned SETS     = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_fetch,
  input  logic            req_store,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [1:0]      fill_kind,
  input  logic [PA_W-1:0] fill_pbase,
  input  logic            flush,
  output logic            hit,
  output logic [PA_W-1:0] paddr,
  output logic            miss
);

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned VPN_W = VA_W - PG_SHIFT;

  acc_kind_e        rd_kind;
  logic [IDX_W-1:0] rd_idx;
  logic [VPN_W-1:0] rd_vpn;
  logic [IDX_W-1:0] wr_idx;
  logic [VPN_W-1:0] wr_vpn;
  logic             fill_ok;
  logic             fill_off_unused;

  logic [VPN_W-1:0]     tag_rd [NUM_KINDS];
  logic [NUM_KINDS-1:0] vld_rd;
  logic [PA_W-1:0]      base_rd;
  logic                 lookup_hit;

  assign rd_kind = req_kind(req_fetch, req_store);
  assign rd_idx  = req_vaddr[PG_SHIFT +: IDX_W];
  assign rd_vpn  = req_vaddr[VA_W-1:PG_SHIFT];
  assign wr_idx  = fill_vaddr[PG_SHIFT +: IDX_W];
  assign wr_vpn  = fill_vaddr[VA_W-1:PG_SHIFT];
  assign fill_off_unused = ^fill_vaddr[PG_SHIFT-1:0];

  // reserved kind, flush and reset all suppress the write
  assign fill_ok = fill_valid && (fill_kind != KIND_RSVD) && !flush && !rst;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tag
    xlt_ram #(.DEPTH(SETS), .WIDTH(VPN_W)) u_tag (
      .clk   (clk),
      .we    (fill_ok && (fill_kind == 2'(k))),
      .waddr (wr_idx),
      .wdata (wr_vpn),
      .raddr (rd_idx),
      .rdata (tag_rd[k])
    );
  end

  xlt_ram #(.DEPTH(SETS), .WIDTH(PA_W)) u_base (
    .clk   (clk),
    .we    (fill_ok),
    .waddr (wr_idx),
    .wdata (fill_pbase),
    .raddr (rd_idx),
    .rdata (base_rd)
  );

  xlt_valid #(.SETS(SETS), .KINDS(NUM_KINDS)) u_vld (
    .clk     (clk),
    .clr     (rst || flush),
    .wr_en   (fill_ok),
    .wr_idx  (wr_idx),
    .wr_kind (fill_kind),
    .rd_idx  (rd_idx),
    .rd_bits (vld_rd)
  );

  assign lookup_hit = req_valid && vld_rd[rd_kind] && (tag_rd[rd_kind] == rd_vpn);

  assign hit   = lookup_hit;
  assign miss  = req_valid && !lookup_hit;
  assign paddr = lookup_hit ? (base_rd + PA_W'(req_vaddr[PG_SHIFT-1:0])) : '0;

endmodule

// File: rtl/xlt_cache_chk.sv
module xlt_cache_chk
  import xlt_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned PG_SHIFT = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_fetch,
  input logic            req_store,
  input logic            fill_valid,
  input logic [VA_W-1:0] fill_vaddr,
  input logic [1:0]      fill_kind,
  input logic [PA_W-1:0] fill_pbase,
  input logic            flush,
  input logic            hit,
  input logic [PA_W-1:0] paddr,
  input logic            miss
);

  logic [1:0]      cur_kind;
  logic [PA_W-1:0] cur_off;
  assign cur_kind = req_kind(req_fetch, req_store);
  assign cur_off  = PA_W'(req_vaddr[PG_SHIFT-1:0]);

  // R5
  hit_miss_split_chk: assert property (@(posedge clk) disable iff (rst)
    (hit || miss) == req_valid && !(hit && miss));

  // R4
  zero_paddr_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> paddr == '0);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hit);

  // R10
  reset_empties_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  // R6
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid) && !$past(flush) && !$past(rst) && $past(fill_kind) != 2'd3
     && req_valid && cur_kind == $past(fill_kind)
     && req_vaddr[VA_W-1:PG_SHIFT] == $past(fill_vaddr[VA_W-1:PG_SHIFT]))
    |-> hit && paddr == $past(fill_pbase) + cur_off);

  // R6
  fill_evicts_other_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid) && !$past(flush) && !$past(rst) && $past(fill_kind) != 2'd3
     && req_valid && cur_kind != $past(fill_kind)
     && req_vaddr[VA_W-1:PG_SHIFT] == $past(fill_vaddr[VA_W-1:PG_SHIFT]))
    |-> miss);

endmodule

bind xlt_cache xlt_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_fetch(req_fetch), .req_store(req_store), .fill_valid(fill_valid),
  .fill_vaddr(fill_vaddr), .fill_kind(fill_kind), .fill_pbase(fill_pbase),
  .flush(flush), .hit(hit), .paddr(paddr), .miss(miss)
);

// File: tb/sim_xlt_cache.sv
`timescale 1ns/1ps
module sim_xlt_cache;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_fetch = 1'b0;
  logic        req_store = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [1:0]  fill_kind = '0;
  logic [31:0] fill_pbase = '0;
  logic        flush = 1'b0;
  logic        hit;
  logic [31:0] paddr;
  logic        miss;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlt_cache u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_fetch(req_fetch), .req_store(req_store), .fill_valid(fill_valid),
    .fill_vaddr(fill_vaddr), .fill_kind(fill_kind), .fill_pbase(fill_pbase),
    .flush(flush), .hit(hit), .paddr(paddr), .miss(miss)
  );

  // reference state derived from the requirements
  bit          m_vld [3][256];
  logic [19:0] m_tag [3][256];
  logic [31:0] m_base [256];

  function automatic int kind_of(input logic f, input logic s);
    if (f) return 2;
    if (s) return 1;
    return 0;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 256; i++) m_vld[k][i] = 0;
  endtask

  task automatic model_edge(input logic r, input logic fl, input logic fv,
                            input logic [31:0] fva, input logic [1:0] fk,
                            input logic [31:0] fb);
    int ix;
    ix = int'(fva[19:12]);
    if (r || fl) model_clear();
    else if (fv && fk != 2'd3) begin
      m_base[ix] = fb;
      for (int k = 0; k < 3; k++) m_vld[k][ix] = (k == int'(fk));
      m_tag[fk][ix] = fva[31:12];
    end
  endtask

  // one cycle: drive at falling edge, compare mid-low phase, then clock
  task automatic step(input logic rv, input logic [31:0] va, input logic f,
                      input logic s, input logic fv, input logic [31:0] fva,
                      input logic [1:0] fk, input logic [31:0] fb,
                      input logic fl, input string tag);
    int k, ix;
    bit eh, em;
    logic [31:0] ep;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_fetch = f; req_store = s;
    fill_valid = fv; fill_vaddr = fva; fill_kind = fk; fill_pbase = fb;
    flush = fl;
    #5;
    k  = kind_of(f, s);
    ix = int'(va[19:12]);
    eh = rv && m_vld[k][ix] && (m_tag[k][ix] == va[31:12]);
    em = rv && !eh;
    ep = eh ? m_base[ix] + {20'd0, va[11:0]} : 32'd0;
    n_vec++;
    if (hit !== eh || miss !== em || paddr !== ep) begin
      n_bad++;
      $display("FAIL %s: hit=%0b miss=%0b paddr=%h expected hit=%0b miss=%0b paddr=%h",
               tag, hit, miss, paddr, eh, em, ep);
    end
    model_edge(rst, fl, fv, fva, fk, fb);
  endtask

  task automatic look(input logic [31:0] va, input int k, input string tag);
    step(1'b1, va, k == 2, k == 1, 1'b0, 32'd0, 2'd0, 32'd0, 1'b0, tag);
  endtask

  task automatic fill(input logic [31:0] va, input logic [1:0] k, input logic [31:0] b);
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, va, k, b, 1'b0, "R6 fill");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] pool_addr();
    logic [11:0] hi;
    logic [7:0]  ix;
    case ($urandom % 3)
      0: hi = 12'h000;
      1: hi = 12'h001;
      default: hi = 12'hFFF;
    endcase
    case ($urandom % 4)
      0: ix = 8'h00;
      1: ix = 8'h01;
      2: ix = 8'h7F;
      default: ix = 8'hFF;
    endcase
    return {hi, ix, 12'($urandom)};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state: everything misses; idle request gives neither flag
    look(32'h0000_0123, 0, "R10 after reset");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, "R5 idle");

    // R6/R2 install a load translation, only load hits
    fill(32'h0001_2000, 2'd0, 32'h8000_0000);
    look(32'h0001_2ABC, 0, "R6 load hits");
    look(32'h0001_2ABC, 1, "R2 store misses");
    look(32'h0001_2ABC, 2, "R2 fetch misses");
    // R4 largest offset
    look(32'h0001_2FFF, 0, "R4 max offset");
    // R1 alias: same set, different page number
    look(32'h0011_2000, 0, "R1 alias misses");

    // R6 store refill evicts the load kind of the same set
    fill(32'h0001_2000, 2'd1, 32'h9000_0000);
    look(32'h0001_2004, 1, "R6 store hits");
    look(32'h0001_2004, 0, "R6 load evicted");

    // R2 fetch flag wins over store flag
    fill(32'h0003_4000, 2'd2, 32'hA000_0000);
    step(1'b1, 32'h0003_4010, 1'b1, 1'b1, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, "R2 fetch priority");

    // R7 reserved kind changes nothing
    fill(32'h0003_4000, 2'd3, 32'hDEAD_0000);
    look(32'h0003_4010, 2, "R7 reserved ignored");

    // R4 wrap of base plus offset
    fill(32'h0005_6000, 2'd0, 32'hFFFF_FF00);
    look(32'h0005_6200, 0, "R4 wrap");

    // R9 lookup and refill to same set in one cycle sees old contents
    step(1'b1, 32'h0005_6010, 1'b0, 1'b0, 1'b1, 32'h0015_6000, 2'd0, 32'h1111_0000, 1'b0, "R9 same cycle");
    look(32'h0015_6010, 0, "R9 new contents next cycle");

    // R8 flush wins over a simultaneous refill
    step(1'b1, 32'h0003_4000, 1'b1, 1'b0, 1'b1, 32'h0007_7000, 2'd0, 32'h2222_0000, 1'b1, "R8 flush cycle");
    look(32'h0003_4000, 2, "R8 flushed");
    look(32'h0007_7000, 0, "R8 refill dropped");

    // R10 reset after content
    fill(32'h0008_8000, 2'd0, 32'h3333_0000);
    look(32'h0008_8000, 0, "R10 before reset");
    do_reset();
    look(32'h0008_8000, 0, "R10 after second reset");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) != 0, pool_addr(), ($urandom % 3) == 0, ($urandom % 2) == 0,
           ($urandom % 3) == 0, pool_addr(), 2'($urandom), $urandom,
           ($urandom % 64) == 0, "R1 R3 R4 R5 R6 R7 R8 R9 random");
    end

    finish_run();
  end

endmodule